// File: doc/BRIEF.md
# Oversampling Serial Receiver with Status Flags

This block receives asynchronous serial characters on a line that rests high. It runs on a single clock at sixteen times the bit rate. It finds each start edge, times the middle of every bit from that edge, and builds the character in a shift register. When the first stop bit is sampled, the character moves into a holding register. The block then raises a data-ready flag and sets flags for overrun, framing error and parity error.

A host reads the holding register while data-ready is high. It then pulls the active-low clear input low to acknowledge the character. A 4-bit configuration word selects the character length and the parity mode. The receiver takes a snapshot of this word at each start edge, so a change in the middle of a character has no effect on that character. The serial input passes through a two-flop synchronizer. The active-low reset is asserted asynchronously and released synchronously inside the block.

Top module: `sio_rx`

## Requirements
- R1: While reset is held and right after it is released, `rx_data` is 0 and `data_ready`, `overrun`, `frame_err` and `parity_err` are all low.
- R2: A start is detected one clock after the synchronized line (two flops after `rx_in`) first shows a high-to-low change. The start bit is sampled again at the eighth clock after detection. If the line is high at that point, the event is a glitch: the receiver returns to idle and no character is produced.
- R3: Data bits arrive LSB first and are each sampled 16 clocks after the previous sample point. The character length is `cfg_word[1:0]` + 5 bits (code 0 gives 5 bits, code 3 gives 8 bits). The character is right-justified in `rx_data`, and the unused high bits read 0.
- R4: When `cfg_word[2]` is 1, there is no parity bit and `parity_err` stays low. When `cfg_word[2]` is 0, one parity bit follows the data bits: `cfg_word[3]`=1 selects even parity and 0 selects odd parity. `parity_err` is high when the received parity bit does not match.
- R5: `rx_data` is loaded at the clock edge that samples the centre of the first stop bit. `data_ready` rises one clock later. For an 8-bit character without parity, `rx_data` changes 155 clocks after `rx_in` falls for the start bit. `rx_data` holds its value between loads.
- R6: `frame_err` is high for a character whose first stop bit was sampled low, and low otherwise. It updates together with `data_ready`.
- R7: `overrun` is loaded at every transfer. It goes high if `data_ready` was still high at that transfer, and low if it was not.
- R8: A low level on `dr_clr_n` clears `data_ready`. A load of the holding register takes priority over the clear.
- R9: After the first stop bit is sampled, the receiver immediately looks for the next start edge. Characters sent back to back with one stop bit are all received.
- R10: Asserting `rst_n` at any time clears the holding register and all flags at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk16 | input | 1 | Receive clock, 16 times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in | input | 1 | Serial line, idle high |
| cfg_word | input | 4 | [1:0] length code, [2] parity off, [3] even parity |
| dr_clr_n | input | 1 | Active-low clear of data-ready |
| rx_data | output | 8 | Received character, right-justified |
| data_ready | output | 1 | A character is waiting in rx_data |
| overrun | output | 1 | The last transfer overwrote an unacknowledged character |
| frame_err | output | 1 | The first stop bit of the last character was low |
| parity_err | output | 1 | The parity bit of the last character did not match |

## Verification
The bench sends a short low pulse that goes high again before the start-bit centre. A receiver that does not recheck the start bit would build a garbage character from it and raise data-ready. It also counts clocks from the start edge to the buffer load and then to data-ready. A sampling counter that is off by one would shift that load by a clock, or would sample at the bit edges and corrupt back-to-back characters. It checks a 5-bit character sent with all ones, where stale shift-register bits would show up as nonzero high bits. It also leaves data-ready set across a second character, where a receiver that wrongly ties overrun to the clear input would miss the overrun or fail to drop it on the next clean transfer.

// File: rtl/sio_rx_pkg.sv
package sio_rx_pkg;
  localparam int DATA_W  = 8;
  localparam int MIN_LEN = 5;

  typedef struct packed {
    logic       even;
    logic       par_off;
    logic [1:0] len;
  } rx_cfg_t;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_START = 3'd1,
    S_DATA  = 3'd2,
    S_PAR   = 3'd3,
    S_STOP  = 3'd4
  } rx_state_e;
endpackage

// File: rtl/sio_rx_sync.sv
module sio_rx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff_q <= {STAGES{RST_VAL}};
    else        ff_q <= {ff_q[STAGES-2:0], d};
  end

  assign q = ff_q[STAGES-1];
endmodule

// File: rtl/sio_rx_frame.sv
module sio_rx_frame
  import sio_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line,
  input  rx_cfg_t           cfg_in,
  output logic              xfer,
  output logic [DATA_W-1:0] xfer_data,
  output logic              xfer_fe,
  output logic              xfer_pe
);
  localparam int CNT_W = $clog2(OSR);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OSR/2 - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(OSR - 1);

  rx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [2:0]        idx_q, idx_d;
  logic [DATA_W-1:0] sr_q, sr_d;
  logic              par_q, par_d;
  logic              prev_q;
  rx_cfg_t           cfg_q, cfg_d;
  logic [3:0]        len_bits;
  logic              at_mid, at_full;

  assign len_bits = 4'(MIN_LEN) + {2'b00, cfg_q.len};
  assign at_mid   = (cnt_q == MID);
  assign at_full  = (cnt_q == FULL);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    sr_d    = sr_q;
    par_d   = par_q;
    cfg_d   = cfg_q;
    unique case (state_q)
      S_IDLE: begin
        cnt_d = '0;
        if (prev_q && !line) begin
          state_d = S_START;
          cfg_d   = cfg_in;
          par_d   = 1'b0;
          idx_d   = '0;
        end
      end
      S_START: begin
        cnt_d = cnt_q + 1'b1;
        if (at_mid) begin
          cnt_d   = '0;
          state_d = line ? S_IDLE : S_DATA;
        end
      end
      S_DATA: begin
        cnt_d = at_full ? '0 : cnt_q + 1'b1;
        if (at_full) begin
          sr_d  = {line, sr_q[DATA_W-1:1]};
          par_d = par_q ^ line;
          if (idx_q == 3'(len_bits - 4'd1))
            state_d = cfg_q.par_off ? S_STOP : S_PAR;
          else
            idx_d = idx_q + 1'b1;
        end
      end
      S_PAR: begin
        cnt_d = at_full ? '0 : cnt_q + 1'b1;
        if (at_full) begin
          par_d   = par_q ^ line;
          state_d = S_STOP;
        end
      end
      S_STOP: begin
        cnt_d = at_full ? '0 : cnt_q + 1'b1;
        if (at_full) state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sr_q    <= '0;
      par_q   <= 1'b0;
      prev_q  <= 1'b1;
      cfg_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      sr_q    <= sr_d;
      par_q   <= par_d;
      prev_q  <= line;
      cfg_q   <= cfg_d;
    end
  end

  assign xfer      = (state_q == S_STOP) && at_full;
  assign xfer_data = sr_q >> (DATA_W - int'(len_bits));
  assign xfer_fe   = ~line;
  assign xfer_pe   = cfg_q.par_off ? 1'b0 : (par_q ^ ~cfg_q.even);

  // R2: a start that is high again at its centre is dropped
  p_glitch_abort_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_START && at_mid && line) |=> (state_q == S_IDLE));

  // R3: bits above the configured length are zero at transfer
  p_unused_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |-> ((xfer_data >> len_bits) == '0));

  // R4: no parity error reported while parity is off
  p_par_off_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && cfg_q.par_off) |-> !xfer_pe);

  // R9: hunting for the next start right after the first stop sample
  p_rearm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> (state_q == S_IDLE));
endmodule

// File: rtl/sio_rx_status.sv
module sio_rx_status
  import sio_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer,
  input  logic [DATA_W-1:0] xfer_data,
  input  logic              fe_in,
  input  logic              pe_in,
  input  logic              clr_n,
  output logic [DATA_W-1:0] rbr,
  output logic              dr,
  output logic              oe,
  output logic              fe,
  output logic              pe
);
  logic [DATA_W-1:0] rbr_q, rbr_d;
  logic dr_q, dr_d, oe_q, oe_d, fe_q, fe_d, pe_q, pe_d;
  logic pend_q, pend_d, feh_q, feh_d, peh_q, peh_d;

  always_comb begin
    rbr_d  = rbr_q;
    dr_d   = dr_q;
    oe_d   = oe_q;
    fe_d   = fe_q;
    pe_d   = pe_q;
    pend_d = 1'b0;
    feh_d  = feh_q;
    peh_d  = peh_q;
    if (xfer) begin
      rbr_d  = xfer_data;
      oe_d   = dr_q;
      pend_d = 1'b1;
      feh_d  = fe_in;
      peh_d  = pe_in;
    end
    if (pend_q) begin
      dr_d = 1'b1;
      fe_d = feh_q;
      pe_d = peh_q;
    end else if (!clr_n) begin
      dr_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbr_q  <= '0;
      dr_q   <= 1'b0;
      oe_q   <= 1'b0;
      fe_q   <= 1'b0;
      pe_q   <= 1'b0;
      pend_q <= 1'b0;
      feh_q  <= 1'b0;
      peh_q  <= 1'b0;
    end else begin
      rbr_q  <= rbr_d;
      dr_q   <= dr_d;
      oe_q   <= oe_d;
      fe_q   <= fe_d;
      pe_q   <= pe_d;
      pend_q <= pend_d;
      feh_q  <= feh_d;
      peh_q  <= peh_d;
    end
  end

  assign rbr = rbr_q;
  assign dr  = dr_q;
  assign oe  = oe_q;
  assign fe  = fe_q;
  assign pe  = pe_q;

  // R5: ready follows the buffer load by one clock
  p_ready_after_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |-> ##2 dr_q);

  // R5: the holding register only changes on a transfer
  p_rbr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> $stable(rbr_q));

  // R7: a transfer onto an unacknowledged character flags overrun
  p_overrun_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && dr_q) |=> oe_q);

  // R8: clear input drops ready when no load is pending
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_n && !pend_q) |=> !dr_q);
endmodule

// File: rtl/sio_rx.sv
module sio_rx
  import sio_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk16,
  input  logic       rst_n,
  input  logic       rx_in,
  input  logic [3:0] cfg_word,
  input  logic       dr_clr_n,
  output logic [7:0] rx_data,
  output logic       data_ready,
  output logic       overrun,
  output logic       frame_err,
  output logic       parity_err
);
  logic              rst_int_n;
  logic              line;
  logic              xfer, xfer_fe, xfer_pe;
  logic [DATA_W-1:0] xfer_data;
  rx_cfg_t           cfg;

  assign cfg = rx_cfg_t'(cfg_word);

  sio_rx_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk16), .rst_n(rst_n), .d(1'b1), .q(rst_int_n));

  sio_rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_line_sync (
    .clk(clk16), .rst_n(rst_int_n), .d(rx_in), .q(line));

  sio_rx_frame #(.OSR(OSR)) u_frame (
    .clk(clk16), .rst_n(rst_int_n), .line(line), .cfg_in(cfg),
    .xfer(xfer), .xfer_data(xfer_data), .xfer_fe(xfer_fe), .xfer_pe(xfer_pe));

  sio_rx_status u_status (
    .clk(clk16), .rst_n(rst_int_n), .xfer(xfer), .xfer_data(xfer_data),
    .fe_in(xfer_fe), .pe_in(xfer_pe), .clr_n(dr_clr_n),
    .rbr(rx_data), .dr(data_ready), .oe(overrun), .fe(frame_err), .pe(parity_err));
endmodule

// File: tb/sio_rx_bench.sv
module sio_rx_bench;
  logic       clk16 = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_in = 1'b1;
  logic       dr_clr_n = 1'b1;
  logic [3:0] cfg_word = 4'd0;
  logic [7:0] rx_data;
  logic       data_ready, overrun, frame_err, parity_err;

  sio_rx u_sio_rx (
    .clk16(clk16), .rst_n(rst_n), .rx_in(rx_in), .cfg_word(cfg_word),
    .dr_clr_n(dr_clr_n), .rx_data(rx_data), .data_ready(data_ready),
    .overrun(overrun), .frame_err(frame_err), .parity_err(parity_err));

  always #2 clk16 = ~clk16;

  typedef struct {
    logic [7:0] data;
    logic       fe;
    logic       pe;
    logic       oe;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   auto_mon = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic bit_time();
    repeat (16) @(negedge clk16);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk16);
  endtask

  // driver: pushes the expected result, then drives the frame
  task automatic send(input logic [7:0] d, input logic [3:0] cfg, input bit bad_par,
                      input bit bad_stop, input int stops, input bit push);
    int         len;
    logic [7:0] dm;
    logic       pbit;
    exp_t       e;
    len  = 5 + int'(cfg[1:0]);
    dm   = d & 8'((1 << len) - 1);
    pbit = cfg[3] ? ^dm : ~^dm;
    if (bad_par) pbit = ~pbit;
    e.data = dm;
    e.fe   = bad_stop;
    e.pe   = !cfg[2] && bad_par;
    e.oe   = 1'b0;
    if (push) exp_q.push_back(e);
    cfg_word = cfg;
    rx_in = 1'b0;
    bit_time();
    for (int i = 0; i < len; i++) begin
      rx_in = dm[i];
      bit_time();
    end
    if (!cfg[2]) begin
      rx_in = pbit;
      bit_time();
    end
    rx_in = !bad_stop;
    bit_time();
    rx_in = 1'b1;
    for (int i = 1; i < stops; i++) bit_time();
  endtask

  // monitor: compares each new character against the queue, then acknowledges it
  initial begin
    logic dr_prev;
    bit   pulsed;
    exp_t e;
    dr_prev = 1'b0;
    pulsed  = 1'b0;
    forever begin
      @(negedge clk16);
      if (pulsed) begin
        dr_clr_n = 1'b1;
        pulsed   = 1'b0;
      end
      if (auto_mon && data_ready && !dr_prev) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected character", int'(rx_data), 0);
        end else begin
          e = exp_q.pop_front();
          check(rx_data == e.data, "R3 data", int'(rx_data), int'(e.data));
          check(frame_err == e.fe, "R6 framing", int'(frame_err), int'(e.fe));
          check(parity_err == e.pe, "R4 parity", int'(parity_err), int'(e.pe));
          check(overrun == e.oe, "R7 overrun", int'(overrun), int'(e.oe));
        end
        dr_clr_n = 1'b0;
        pulsed   = 1'b1;
      end
      dr_prev = data_ready;
    end
  end

  initial begin
    repeat (10000) @(negedge clk16);
    check(1'b0, "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk16);
    // R1 and R10: state while reset is held
    check(data_ready == 1'b0 && overrun == 1'b0, "R1 flags in reset", int'({data_ready, overrun}), 0);
    check(frame_err == 1'b0 && parity_err == 1'b0, "R1 errors in reset", int'({frame_err, parity_err}), 0);
    check(rx_data == 8'h00, "R10 buffer in reset", int'(rx_data), 0);
    rst_n = 1'b1;
    idle(5);
    check(data_ready == 1'b0, "R1 ready after release", int'(data_ready), 0);

    auto_mon = 1'b1;
    send(8'hA5, 4'b0111, 0, 0, 1, 1); idle(20);   // R3 8-bit, no parity
    send(8'hFF, 4'b0100, 0, 0, 1, 1); idle(20);   // R3 5-bit, high bits zero
    send(8'h2D, 4'b1001, 0, 0, 1, 1); idle(20);   // R4 6-bit even
    send(8'h5A, 4'b0010, 0, 0, 1, 1); idle(20);   // R4 7-bit odd
    send(8'hC3, 4'b1011, 1, 0, 1, 1); idle(20);   // R4 wrong parity
    send(8'h3C, 4'b0111, 1, 0, 1, 1); idle(20);   // R4 parity off, flag low
    send(8'h81, 4'b1111, 0, 1, 1, 1); idle(40);   // R6 stop bit low
    // R9 back to back, one stop bit
    send(8'h12, 4'b1011, 0, 0, 1, 1);
    send(8'h34, 4'b1011, 0, 0, 1, 1);
    send(8'h56, 4'b0011, 0, 0, 2, 1);
    idle(40);
    check(exp_q.size() == 0, "R9 all back-to-back characters seen", exp_q.size(), 0);

    // R2 glitch shorter than half a bit
    rx_in = 1'b0;
    idle(4);
    rx_in = 1'b1;
    idle(60);
    check(data_ready == 1'b0, "R2 glitch gives no ready", int'(data_ready), 0);
    check(rx_data == 8'h56, "R2 glitch leaves buffer", int'(rx_data), 32'h56);
    send(8'h9E, 4'b0111, 0, 0, 1, 1); idle(40);   // R2 normal start after glitch
    check(exp_q.size() == 0, "R2 character after glitch", exp_q.size(), 0);
    auto_mon = 1'b0;
    idle(4);

    // R5 load time and ready one clock later
    fork
      send(8'h3C, 4'b0111, 0, 0, 1, 0);
      begin
        n = 0;
        while (rx_data != 8'h3C && n < 400) begin
          @(negedge clk16);
          n++;
        end
        check(n == 155, "R5 load at first stop centre", n, 155);
        check(data_ready == 1'b0, "R5 ready low at load", int'(data_ready), 0);
        @(negedge clk16);
        check(data_ready == 1'b1, "R5 ready one clock later", int'(data_ready), 1);
      end
    join
    idle(10);

    // R7 overrun while ready still set
    send(8'h77, 4'b0111, 0, 0, 1, 0); idle(30);
    check(rx_data == 8'h77, "R7 new data on overrun", int'(rx_data), 32'h77);
    check(overrun == 1'b1, "R7 overrun set", int'(overrun), 1);
    // R8 clear input
    dr_clr_n = 1'b0;
    @(negedge clk16);
    dr_clr_n = 1'b1;
    check(data_ready == 1'b0, "R8 clear drops ready", int'(data_ready), 0);
    check(rx_data == 8'h77, "R8 clear keeps data", int'(rx_data), 32'h77);
    send(8'h11, 4'b0111, 0, 0, 1, 0); idle(30);
    check(overrun == 1'b0, "R7 overrun cleared by clean load", int'(overrun), 0);
    check(data_ready == 1'b1 && rx_data == 8'h11, "R7 clean load data", int'(rx_data), 32'h11);

    // R10 reset during operation
    rst_n = 1'b0;
    @(negedge clk16);
    check(rx_data == 8'h00 && data_ready == 1'b0, "R10 reset clears buffer",
          int'({data_ready, rx_data}), 0);
    check(overrun == 1'b0 && frame_err == 1'b0 && parity_err == 1'b0, "R10 reset clears flags",
          int'({overrun, frame_err, parity_err}), 0);
    rst_n = 1'b1;
    idle(5);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule